// File: doc/BRIEF.md
# Two-Wire Single-Register Wiper Target

This block is a target on a two-wire I2C bus that answers to a single fixed 7-bit address and owns one 7-bit wiper register. No register pointer or sub-address exists. The only thing on the bus after the address byte is the register itself. A controller that addresses the block with the write direction may send any number of data bytes, and each of them replaces the register value. A controller that addresses it with the read direction receives the register value again and again until it declines a byte.

The bus lines are sampled on the system clock through two-flop synchronisers. START and STOP are recognised from SDA edges while SCL is high. The block only pulls SDA low, through an enable output, and it changes that enable only while SCL is low. The register value is presented continuously on a parallel output for the analog part that it controls.

Top module: `wiper_i2c_target`

## Requirements
- R1: After reset the wiper output is 0x40 and SDA is released (pull enable 0).
- R2: An address byte whose upper seven bits equal 0101111 is acknowledged, both with the write direction (byte 0x5E) and with the read direction (byte 0x5F).
- R3: An address byte with any other upper seven bits is not acknowledged. Every bit after it, data included, is then ignored and never acknowledged until the next START.
- R4: In a write, every data byte is acknowledged, and the register takes that byte's value at the SCL falling edge that opens its acknowledge bit. Successive bytes overwrite the register one after another.
- R5: Bit 7 of a written data byte is ignored; the register takes bits 6..0.
- R6: A byte cut short by STOP or by a repeated START before its acknowledge bit begins leaves the register unchanged.
- R7: In a read, each byte is the value {0, wiper[6:0]} sent MSB first, and the same value repeats for every byte that the controller acknowledges.
- R8: After the eighth bit of a read byte the block releases SDA for the controller's acknowledge. After a not-acknowledge it keeps SDA released until the next START or STOP.
- R9: The SDA pull enable changes only while SCL is low, except for the release that START or STOP forces.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, as seen on the pin |
| sda_i | input | 1 | Bus data line, as seen on the pin |
| sda_pull_o | output | 1 | 1 drives SDA low; 0 releases it |
| wiper_o | output | 7 | Current wiper register value |

## Verification
Each bus edge passes through two synchroniser flops and one edge-detect register, so the register commit and every change of the pull enable appear three clock cycles after the SCL edge that causes them. The bench holds each SCL phase for 16 clock cycles and samples SDA and the wiper output 24 cycles after the falling edge that opens a bit, in the middle of the high phase. Expected values are queued by the driver tasks as each byte completes. A monitor compares them on the falling clock edge, after the commit for that byte has landed and before the next commit can happen.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
    localparam int BYTE_W  = 8;
    localparam int WIPER_W = BYTE_W - 1;
    localparam int CNT_W   = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } bus_st_e;

    typedef struct packed {
        bus_st_e              st;
        logic [CNT_W-1:0]     cnt;
        logic [BYTE_W-1:0]    sh;
        logic                 ack_ph;
        logic                 rd;
        logic                 more;
        logic                 pull;
        logic [WIPER_W-1:0]   wiper;
    } eng_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_chain;
        logic [STAGES-1:0] sda_chain;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.scl_chain = {s_q.scl_chain[STAGES-2:0], scl_i};
        s_d.sda_chain = {s_q.sda_chain[STAGES-2:0], sda_i};
        s_d.scl_prev  = s_q.scl_chain[STAGES-1];
        s_d.sda_prev  = s_q.sda_chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_s     = s_q.scl_chain[STAGES-1];
    assign sda_s     = s_q.sda_chain[STAGES-1];
    assign scl_rise  = scl_s & ~s_q.scl_prev;
    assign scl_fall  = ~scl_s & s_q.scl_prev;
    assign start_det = scl_s & s_q.scl_prev & s_q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & s_q.scl_prev & ~s_q.sda_prev & sda_s;
endmodule

// File: rtl/wiper_bus_engine.sv
module wiper_bus_engine
    import wiper_pkg::*;
#(
    parameter logic [WIPER_W-1:0] TARGET_ADDR = 7'h2F,
    parameter logic [WIPER_W-1:0] RESET_WIPER = 7'h40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_s,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    output logic               pull,
    output logic [WIPER_W-1:0] wiper
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam eng_t RST_ENG = '{
        st:     ST_IDLE,
        cnt:    '0,
        sh:     '0,
        ack_ph: 1'b0,
        rd:     1'b0,
        more:   1'b0,
        pull:   1'b0,
        wiper:  RESET_WIPER
    };

    eng_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (start_det) begin
            e_d.st     = ST_ADDR;
            e_d.cnt    = '0;
            e_d.ack_ph = 1'b0;
            e_d.pull   = 1'b0;
        end else if (stop_det) begin
            e_d.st     = ST_IDLE;
            e_d.ack_ph = 1'b0;
            e_d.pull   = 1'b0;
        end else begin
            unique case (e_q.st)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        e_d.sh  = {e_q.sh[BYTE_W-2:0], sda_s};
                        e_d.cnt = e_q.cnt + 1'b1;
                        if (e_q.cnt == LAST_BIT) begin
                            e_d.ack_ph = 1'b0;
                            if (e_q.st == ST_WDATA) begin
                                e_d.st = ST_WACK;
                            end else if (e_q.sh[WIPER_W-1:0] == TARGET_ADDR) begin
                                e_d.st = ST_AACK;
                                e_d.rd = sda_s;
                            end else begin
                                e_d.st = ST_SKIP;
                            end
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        if (!e_q.ack_ph) begin
                            e_d.pull   = 1'b1;
                            e_d.ack_ph = 1'b1;
                        end else begin
                            e_d.ack_ph = 1'b0;
                            e_d.cnt    = '0;
                            if (e_q.rd) begin
                                e_d.st   = ST_RDATA;
                                e_d.sh   = {1'b0, e_q.wiper};
                                e_d.pull = 1'b1;
                            end else begin
                                e_d.st   = ST_WDATA;
                                e_d.pull = 1'b0;
                            end
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        if (!e_q.ack_ph) begin
                            e_d.pull   = 1'b1;
                            e_d.ack_ph = 1'b1;
                            e_d.wiper  = e_q.sh[WIPER_W-1:0];
                        end else begin
                            e_d.pull   = 1'b0;
                            e_d.ack_ph = 1'b0;
                            e_d.cnt    = '0;
                            e_d.st     = ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (e_q.cnt == LAST_BIT) begin
                            e_d.pull = 1'b0;
                            e_d.cnt  = '0;
                            e_d.more = 1'b0;
                            e_d.st   = ST_RACK;
                        end else begin
                            e_d.cnt  = e_q.cnt + 1'b1;
                            e_d.sh   = {e_q.sh[BYTE_W-2:0], 1'b0};
                            e_d.pull = ~e_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        e_d.more = ~sda_s;
                    end else if (scl_fall) begin
                        if (e_q.more) begin
                            e_d.st   = ST_RDATA;
                            e_d.sh   = {1'b0, e_q.wiper};
                            e_d.pull = 1'b1;
                            e_d.cnt  = '0;
                        end else begin
                            e_d.st = ST_SKIP;
                        end
                    end
                end
                default: begin
                    e_d.pull = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= RST_ENG;
        else        e_q <= e_d;
    end

    assign pull  = e_q.pull;
    assign wiper = e_q.wiper;
endmodule

// File: rtl/wiper_i2c_target.sv
module wiper_i2c_target
    import wiper_pkg::*;
#(
    parameter logic [WIPER_W-1:0] TARGET_ADDR = 7'h2F,
    parameter logic [WIPER_W-1:0] RESET_WIPER = 7'h40,
    parameter int                 SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    output logic [WIPER_W-1:0] wiper_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    wiper_bus_engine #(
        .TARGET_ADDR(TARGET_ADDR),
        .RESET_WIPER(RESET_WIPER)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .pull      (sda_pull_o),
        .wiper     (wiper_o)
    );
endmodule

// File: rtl/wiper_i2c_checker.sv
module wiper_i2c_checker
    import wiper_pkg::*;
#(
    parameter logic [WIPER_W-1:0] RESET_WIPER = 7'h40
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_s,
    input logic               scl_fall,
    input logic               start_det,
    input logic               stop_det,
    input logic               sda_pull_o,
    input logic [WIPER_W-1:0] wiper_o
);
    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (wiper_o == RESET_WIPER && !sda_pull_o)); // R1

    AST_COMMIT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper_o) |-> $past(scl_fall)); // R4

    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_pull_o); // R3

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull_o); // R8

    AST_PULL_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull_o) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s)); // R9
endmodule

bind wiper_i2c_target wiper_i2c_checker #(
    .RESET_WIPER(RESET_WIPER)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_pull_o (sda_pull_o),
    .wiper_o    (wiper_o)
);

// File: tb/wiper_i2c_target_test.sv
module wiper_i2c_target_test;
    localparam int HALF = 16;
    localparam logic [7:0] WR_ADDR = 8'h5E;
    localparam logic [7:0] RD_ADDR = 8'h5F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_tb = 1'b1;
    logic sda_pull;
    logic [6:0] wiper;
    wire  sda_line = sda_tb & ~sda_pull;

    int checks = 0;
    int fails = 0;
    int r9_viol = 0;
    bit done = 1'b0;

    typedef struct {
        string req;
        int    exp;
        int    act;
        bit    use_wiper;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    wiper_i2c_target uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .wiper_o    (wiper)
    );

    // Monitor: pop expected items and compare against design results.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            int act;
            it = sb.pop_front();
            act = it.use_wiper ? int'(wiper) : it.act;
            checks++;
            if (act != it.exp) begin
                fails++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", it.req, act, it.exp);
            end
        end
    end

    // R9 observer: pull enable must not move while raw SCL is high.
    logic prev_pull = 1'b0;
    always @(posedge clk) begin
        if (rst_n && scl && (sda_pull != prev_pull)) r9_viol++;
        prev_pull <= sda_pull;
    end

    task automatic push_val(input string req, input int exp, input int act);
        item_t it;
        it.req = req; it.exp = exp; it.act = act; it.use_wiper = 1'b0;
        sb.push_back(it);
    endtask

    task automatic push_wiper(input string req, input int exp);
        item_t it;
        it.req = req; it.exp = exp; it.act = 0; it.use_wiper = 1'b1;
        sb.push_back(it);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_tb = 1'b1; scl = 1'b1; wait_clk(HALF);
        sda_tb = 1'b0; wait_clk(HALF);
        scl = 1'b0; wait_clk(HALF);
    endtask

    task automatic bus_restart();
        sda_tb = 1'b1; wait_clk(HALF);
        scl = 1'b1; wait_clk(HALF);
        sda_tb = 1'b0; wait_clk(HALF);
        scl = 1'b0; wait_clk(HALF);
    endtask

    task automatic bus_stop();
        sda_tb = 1'b0; wait_clk(HALF);
        scl = 1'b1; wait_clk(HALF);
        sda_tb = 1'b1; wait_clk(HALF);
    endtask

    task automatic bit_io(input logic b, output logic s);
        wait_clk(HALF/2); sda_tb = b;
        wait_clk(HALF/2); scl = 1'b1;
        wait_clk(HALF/2); s = sda_line;
        wait_clk(HALF/2); scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        logic s;
        for (int i = 7; i > 7 - n; i--) bit_io(b[i], s);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            d[i] = s;
        end
        bit_io(~give_ack, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] d;

        wait_clk(5);
        push_wiper("R1 reset wiper", 'h40);
        push_val("R1 reset pull", 0, int'(sda_pull));
        rst_n = 1'b1;
        wait_clk(HALF);

        // Single write
        bus_start();
        send_byte(WR_ADDR, ack); push_val("R2 write address ack", 1, int'(ack));
        send_byte(8'h15, ack);   push_val("R4 data ack", 1, int'(ack));
        push_wiper("R4 single write", 'h15);
        bus_stop();

        // Multi-byte write, each overwrites
        bus_start();
        send_byte(WR_ADDR, ack);
        send_byte(8'h7F, ack); push_wiper("R4 multi byte 1", 'h7F);
        send_byte(8'h00, ack); push_wiper("R4 multi byte 2", 'h00);
        send_byte(8'h2A, ack); push_wiper("R4 multi byte 3", 'h2A);
        push_val("R4 third byte ack", 1, int'(ack));
        // MSB ignored
        send_byte(8'hC3, ack); push_wiper("R5 msb ignored", 'h43);
        bus_stop();

        // Read, repeated value
        bus_start();
        send_byte(RD_ADDR, ack); push_val("R2 read address ack", 1, int'(ack));
        read_byte(1'b1, d); push_val("R7 read byte 1", 'h43, int'(d));
        read_byte(1'b1, d); push_val("R7 read byte 2", 'h43, int'(d));
        read_byte(1'b0, d); push_val("R7 read last byte", 'h43, int'(d));
        wait_clk(HALF);
        push_val("R8 released after nack", 0, int'(sda_pull));
        bus_stop();

        // Write then repeated START into a read
        bus_start();
        send_byte(WR_ADDR, ack);
        send_byte(8'h11, ack);
        bus_restart();
        send_byte(RD_ADDR, ack); push_val("R2 read after restart ack", 1, int'(ack));
        read_byte(1'b0, d); push_val("R7 read after restart", 'h11, int'(d));
        bus_stop();

        // Wrong address ignored
        bus_start();
        send_byte(8'h80, ack); push_val("R3 wrong address nack", 0, int'(ack));
        send_byte(8'h22, ack); push_val("R3 data after mismatch nack", 0, int'(ack));
        push_wiper("R3 wiper untouched", 'h11);
        bus_stop();

        // Partial byte then STOP
        bus_start();
        send_byte(WR_ADDR, ack);
        send_bits(8'hA0, 4);
        bus_stop();
        push_wiper("R6 partial stop", 'h11);

        // Full 8 bits, STOP while SCL high before the ack bit
        bus_start();
        send_byte(WR_ADDR, ack);
        send_bits(8'h33, 7);
        wait_clk(HALF/2); sda_tb = 1'b0;
        wait_clk(HALF/2); scl = 1'b1;
        wait_clk(HALF);   sda_tb = 1'b1;
        wait_clk(HALF);
        push_wiper("R6 stop before ack", 'h11);

        // Partial byte then repeated START, read back
        bus_start();
        send_byte(WR_ADDR, ack);
        send_bits(8'h55, 5);
        bus_restart();
        send_byte(RD_ADDR, ack);
        read_byte(1'b0, d); push_val("R6 read after restart abort", 'h11, int'(d));
        bus_stop();

        push_val("R9 pull changed only with SCL low", 0, r9_viol);

        wait (sb.size() == 0);
        wait_clk(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule